// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides when a processor core takes a maskable interrupt and then runs a fixed entry sequence. A source counts as active when its enable bit is set and at least one of its pending bits is set. At an instruction boundary, the block takes the interrupt if the global enable flag is high, some source is active, no software-trap handler is in service and no sequence is already running. In that cycle it replaces the fetched opcode with 0x00.

The entry sequence then runs for seven cycles. It pulses a request to clear global enable. It writes the captured return address to the stack as two bytes, low byte first. It loads the program counter with the fixed handler address 0x00FF. A return-from-interrupt strobe raises a request to set global enable again. A source that is still pending therefore re-enters at the next boundary. The block never clears pending bits. Choosing which source to service, decoding instructions and storing stack data are done elsewhere.

Top module: `int_entry_seq`

## Requirements
- R1: Source k occupies pending bits [k*PEND_W +: PEND_W]. It is active when `src_en_i[k]` is 1 and any of its pending bits is 1.
- R2: A take happens in a cycle where `boundary_i`, `gie_i` and some active source are all high, `trap_svc_i` is low and `busy_o` is low. `busy_o` is then high for exactly 7 cycles, starting with the next cycle. Without a take, `busy_o` stays low.
- R3: In the take cycle `opcode_o` is 0x00. In every other cycle `opcode_o` equals `opcode_i`.
- R4: In the first busy cycle, `gie_clr_o` pulses for one cycle.
- R5: In busy cycles 2 and 3, `stk_we_o` is high, and each write strobe decrements the stack pointer. In cycle 2 `stk_data_o` is `next_pc_i[7:0]` as sampled at the take. In cycle 3 it is {1'b0, `next_pc_i[14:8]`}. In all other cycles `stk_we_o` is low.
- R6: In busy cycle 4, `pc_ld_o` is high and `pc_tgt_o` is 0x00FF. In all other cycles `pc_ld_o` is low and `pc_tgt_o` is 0.
- R7: While `trap_svc_i` is high, no take happens.
- R8: A boundary that arrives while `busy_o` is high is ignored, even if `gie_i` is high. `opcode_o` passes through and the sequence length is unchanged.
- R9: `gie_set_o` follows `reti_i` in the same cycle. A boundary in the same cycle as `reti_i` is judged on the old `gie_i`. Once `gie_i` is 1 again, a source that is still pending is taken at the next boundary.
- R10: After reset, `busy_o`, `gie_clr_o`, `stk_we_o` and `pc_ld_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | N_SRC | Per-source enable |
| src_pend_i | input | N_SRC*PEND_W | Per-source pending bits |
| gie_i | input | 1 | Global interrupt enable flag |
| boundary_i | input | 1 | A new instruction is about to start |
| reti_i | input | 1 | Return-from-interrupt strobe |
| trap_svc_i | input | 1 | Software-trap handler in service |
| next_pc_i | input | ADDR_W | Address of the instruction about to run |
| opcode_i | input | OP_W | Fetched opcode |
| opcode_o | output | OP_W | Opcode passed to decode, 0x00 when forced |
| busy_o | output | 1 | Entry sequence in progress |
| gie_clr_o | output | 1 | Request to clear global enable |
| gie_set_o | output | 1 | Request to set global enable |
| stk_we_o | output | 1 | Stack byte write, decrements stack pointer |
| stk_data_o | output | 8 | Stack write byte |
| pc_ld_o | output | 1 | Program counter load |
| pc_tgt_o | output | ADDR_W | Program counter load value |

## Verification
Two pairs of events can fall in the same cycle. A new boundary can coincide with a running sequence, and a return strobe can coincide with a boundary. The first pair is provoked by holding `boundary_i` and `gie_i` high through every busy cycle of about half the sweep sequences. It is judged by requiring an unforced opcode and unchanged step timing. The second pair is provoked by raising `reti_i` and `boundary_i` together while `gie_i` is still 0. It is judged by requiring no take in that cycle and a take at the next boundary after `gie_i` returns to 1.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_LO   = 2'd1,
    STK_HI   = 2'd2
  } stk_sel_e;

  // busy-step numbers of the entry sequence, first busy cycle is 1
  localparam int unsigned STEP_CLR = 1;
  localparam int unsigned STEP_LO  = 2;
  localparam int unsigned STEP_HI  = 3;
  localparam int unsigned STEP_JMP = 4;
endpackage

// File: rtl/ies_active_det.sv
module ies_active_det #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned PEND_W = 2
) (
  input  logic [N_SRC-1:0]        en_i,
  input  logic [N_SRC*PEND_W-1:0] pend_i,
  output logic                    any_o
);
  logic [N_SRC-1:0] act;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign act[k] = en_i[k] & (|pend_i[k*PEND_W +: PEND_W]);
  end

  assign any_o = |act;
endmodule

// File: rtl/ies_step_ctr.sv
module ies_step_ctr #(
  parameter int unsigned ENTRY_CYC = 7,
  localparam int unsigned CNT_W    = $clog2(ENTRY_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  output logic [CNT_W-1:0] step_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (take_i)          cnt_q <= CNT_W'(1);
    else if (cnt_q == LAST)   cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign step_o = cnt_q;
  assign busy_o = (cnt_q != '0);

  a_r2_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !take_i);
  a_r2_step_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/ies_stack_drv.sv
module ies_stack_drv
  import ies_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  stk_sel_e          sel_i,
  output logic              we_o,
  output logic [BYTE_W-1:0] data_o
);
  logic [ADDR_W-1:0] ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ret_q <= '0;
    else if (cap_i) ret_q <= pc_i;
  end

  always_comb begin
    we_o   = 1'b0;
    data_o = '0;
    unique case (sel_i)
      STK_LO: begin we_o = 1'b1; data_o = ret_q[BYTE_W-1:0]; end
      STK_HI: begin we_o = 1'b1; data_o = BYTE_W'(ret_q >> BYTE_W); end
      default: ;
    endcase
  end

  a_r5_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $stable(ret_q));
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import ies_pkg::*;
#(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned PEND_W     = 2,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned OP_W       = 8,
  parameter int unsigned ENTRY_CYC  = 7,
  parameter int unsigned BRANCH_TGT = 32'h0000_00FF,
  localparam int unsigned CNT_W     = $clog2(ENTRY_CYC + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_en_i,
  input  logic [N_SRC*PEND_W-1:0] src_pend_i,
  input  logic                    gie_i,
  input  logic                    boundary_i,
  input  logic                    reti_i,
  input  logic                    trap_svc_i,
  input  logic [ADDR_W-1:0]       next_pc_i,
  input  logic [OP_W-1:0]         opcode_i,
  output logic [OP_W-1:0]         opcode_o,
  output logic                    busy_o,
  output logic                    gie_clr_o,
  output logic                    gie_set_o,
  output logic                    stk_we_o,
  output logic [BYTE_W-1:0]       stk_data_o,
  output logic                    pc_ld_o,
  output logic [ADDR_W-1:0]       pc_tgt_o
);
  logic             any_act;
  logic             take;
  logic [CNT_W-1:0] step;
  stk_sel_e         stk_sel;

  ies_active_det #(.N_SRC(N_SRC), .PEND_W(PEND_W)) i_act (
    .en_i  (src_en_i),
    .pend_i(src_pend_i),
    .any_o (any_act)
  );

  assign take = boundary_i & gie_i & any_act & ~trap_svc_i & ~busy_o;

  ies_step_ctr #(.ENTRY_CYC(ENTRY_CYC)) i_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .step_o(step),
    .busy_o(busy_o)
  );

  always_comb begin
    stk_sel = STK_NONE;
    if (step == CNT_W'(STEP_LO))      stk_sel = STK_LO;
    else if (step == CNT_W'(STEP_HI)) stk_sel = STK_HI;
  end

  ies_stack_drv #(.ADDR_W(ADDR_W)) i_stk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (take),
    .pc_i  (next_pc_i),
    .sel_i (stk_sel),
    .we_o  (stk_we_o),
    .data_o(stk_data_o)
  );

  assign opcode_o  = take ? '0 : opcode_i;
  assign gie_clr_o = (step == CNT_W'(STEP_CLR));
  assign gie_set_o = reti_i;
  assign pc_ld_o   = (step == CNT_W'(STEP_JMP));
  assign pc_tgt_o  = pc_ld_o ? ADDR_W'(BRANCH_TGT) : '0;

  a_r2_take_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && gie_i && any_act && !trap_svc_i && !busy_o) |=> (busy_o && gie_clr_o));
  a_r4_clr_then_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_o |=> (stk_we_o && !gie_clr_o));
  a_r5_two_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stk_we_o) |=> stk_we_o);
  a_r6_jump_after_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_we_o && $past(stk_we_o)) |=> (pc_ld_o && busy_o));
  a_r7_trap_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_svc_i && !busy_o) |=> !busy_o);
  a_r8_busy_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (opcode_o == opcode_i));
endmodule

// File: tb/test_int_entry_seq.sv
module test_int_entry_seq;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [3:0]  src_en_i;
  logic [7:0]  src_pend_i;
  logic        gie_i, boundary_i, reti_i, trap_svc_i;
  logic [14:0] next_pc_i;
  logic [7:0]  opcode_i, opcode_o;
  logic        busy_o, gie_clr_o, gie_set_o, stk_we_o, pc_ld_o;
  logic [7:0]  stk_data_o;
  logic [14:0] pc_tgt_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  int_entry_seq i_int_entry_seq (
    .clk_i(clk), .rst_ni(rst_ni), .src_en_i(src_en_i), .src_pend_i(src_pend_i),
    .gie_i(gie_i), .boundary_i(boundary_i), .reti_i(reti_i), .trap_svc_i(trap_svc_i),
    .next_pc_i(next_pc_i), .opcode_i(opcode_i), .opcode_o(opcode_o), .busy_o(busy_o),
    .gie_clr_o(gie_clr_o), .gie_set_o(gie_set_o), .stk_we_o(stk_we_o),
    .stk_data_o(stk_data_o), .pc_ld_o(pc_ld_o), .pc_tgt_o(pc_tgt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_any(input logic [3:0] en, input logic [7:0] pd);
    for (int k = 0; k < 4; k++)
      if (en[k] && (pd[k*2] || pd[k*2+1])) return 1'b1;
    return 1'b0;
  endfunction

  // expects take at the previous posedge; walks the seven busy cycles
  task automatic run_seq(input logic [14:0] pc, input bit hold_bnd, input logic [7:0] op);
    for (int s = 1; s <= 7; s++) begin
      @(negedge clk);
      boundary_i = hold_bnd;
      opcode_i   = op;
      #1;
      chk("R2 busy", 32'(busy_o), 32'd1);
      chk("R4 gie_clr", 32'(gie_clr_o), 32'(s == 1));
      chk("R5 stk_we", 32'(stk_we_o), 32'(s == 2 || s == 3));
      if (s == 2) chk("R5 low byte", 32'(stk_data_o), 32'(pc[7:0]));
      if (s == 3) chk("R5 high byte", 32'(stk_data_o), 32'({1'b0, pc[14:8]}));
      chk("R6 pc_ld", 32'(pc_ld_o), 32'(s == 4));
      chk("R6 target", 32'(pc_tgt_o), (s == 4) ? 32'h00FF : 32'h0);
      if (hold_bnd) chk("R8 opcode passes", 32'(opcode_o), 32'(op));
    end
    @(negedge clk);
    boundary_i = 1'b0;
    #1;
    chk("R2 busy ends", 32'(busy_o), 32'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    src_en_i = '0; src_pend_i = '0; gie_i = 1'b0; boundary_i = 1'b0;
    reti_i = 1'b0; trap_svc_i = 1'b0; next_pc_i = '0; opcode_i = 8'h5A;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 busy", 32'(busy_o), 32'd0);
    chk("R10 gie_clr", 32'(gie_clr_o), 32'd0);
    chk("R10 stk_we", 32'(stk_we_o), 32'd0);
    chk("R10 pc_ld", 32'(pc_ld_o), 32'd0);
    chk("R3 opcode idle", 32'(opcode_o), 32'h5A);
    rst_ni = 1'b1;

    // R1 R2 R3 R8: full sweep over enable, pending and global enable
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 16; e++)
        for (int p = 0; p < 256; p++) begin
          logic [14:0] pc;
          logic [7:0]  op;
          bit          tk;
          pc = 15'(e * 977 + p * 131 + g * 4099 + 3);
          op = 8'(p ^ (e << 4)) | 8'h01;
          @(negedge clk);
          src_en_i = 4'(e); src_pend_i = 8'(p); gie_i = 1'(g);
          trap_svc_i = 1'b0; boundary_i = 1'b1; next_pc_i = pc; opcode_i = op;
          #1;
          tk = (g == 1) && exp_any(4'(e), 8'(p));
          chk("R1 R3 opcode", 32'(opcode_o), tk ? 32'h0 : 32'(op));
          if (tk) run_seq(pc, p[0], op);
          else begin
            @(negedge clk);
            boundary_i = 1'b0;
            #1;
            chk("R2 no take", 32'(busy_o), 32'd0);
          end
        end

    // R2: no boundary, no take
    @(negedge clk);
    src_en_i = 4'hF; src_pend_i = 8'hFF; gie_i = 1'b1; boundary_i = 1'b0; opcode_i = 8'h77;
    #1;
    chk("R2 no boundary op", 32'(opcode_o), 32'h77);
    @(negedge clk); #1;
    chk("R2 no boundary busy", 32'(busy_o), 32'd0);

    // R7: trap handler in service blocks entry
    @(negedge clk);
    trap_svc_i = 1'b1; boundary_i = 1'b1; opcode_i = 8'h3C;
    #1;
    chk("R7 opcode", 32'(opcode_o), 32'h3C);
    @(negedge clk);
    boundary_i = 1'b0;
    #1;
    chk("R7 busy", 32'(busy_o), 32'd0);
    trap_svc_i = 1'b0;

    // R9: return strobe coinciding with a boundary while global enable is still 0
    @(negedge clk);
    gie_i = 1'b0; reti_i = 1'b0; boundary_i = 1'b0;
    #1;
    chk("R9 set idle", 32'(gie_set_o), 32'd0);
    @(negedge clk);
    reti_i = 1'b1; boundary_i = 1'b1; opcode_i = 8'h91; next_pc_i = 15'h4321;
    #1;
    chk("R9 set", 32'(gie_set_o), 32'd1);
    chk("R9 old gie op", 32'(opcode_o), 32'h91);
    @(negedge clk);
    reti_i = 1'b0; gie_i = 1'b1; boundary_i = 1'b1;
    #1;
    chk("R9 no take at reti", 32'(busy_o), 32'd0);
    chk("R9 retake op", 32'(opcode_o), 32'h0);
    run_seq(15'h4321, 1'b1, 8'h91);

    summary();
    $finish;
  end
endmodule